// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block is a small fully associative cache of page translations. Each of its entries pairs a virtual page number with a physical page number, a global flag and a 12-bit context tag. A lookup presents a virtual page and gets back, one cycle later, a hit flag and the physical page. A fill writes a freshly fetched descriptor into the cache. The fill stands in for the table walk after a miss, and the new entry is tagged with the context that is active at that moment.

A control-register write port loads a new table-base value. Its low 12 bits become the active context. A feature-enable input is sampled with every such write and selects how the write treats stored entries. With tagging off, a write empties the cache. With tagging on, a write keeps the stored entries and can, through bit 63 of the written value, drop only the non-global entries of the newly loaded context. A separate invalidate-by-context port clears the non-global entries of any chosen context. Because entries of several contexts can live side by side, a context switch does not throw away useful translations.

Top module: `tlb_ctx_cache`

## Requirements
- R1: After reset every entry is invalid, the active context is 0 and `rsp_valid` is low.
- R2: A lookup request accepted at a clock edge gives `rsp_valid`=1 in the following cycle. In that cycle `rsp_hit` and `rsp_ppn` are valid: `rsp_ppn` is the stored physical page on a hit and 0 on a miss.
- R3: A fill is tagged with the context active when it is written. A non-global entry only hits while the active context equals its tag, and under any other context it reads as a miss.
- R4: An entry filled with `fill_global`=1 hits under every context.
- R5: A write on `cr_wr` makes `cr_data[11:0]` the active context (`cur_ctx`) and `cr_data[62:12]` the table base (`tbl_base`), both visible in the next cycle.
- R6: A `cr_wr` with `tag_en`=0 invalidates every entry, global ones included.
- R7: A `cr_wr` with `tag_en`=1 and `cr_data[63]`=0 leaves every entry intact.
- R8: A `cr_wr` with `tag_en`=1 and `cr_data[63]`=1 invalidates the non-global entries tagged with `cr_data[11:0]`. Global entries and entries of other contexts stay.
- R9: An `inv_req` invalidates the non-global entries tagged `inv_ctx`, and lookups from the next cycle on miss them. Global entries and entries of other contexts stay.
- R10: A fill uses the lowest-numbered invalid entry whenever one exists, and does not advance the replacement pointer.
- R11: When all 8 entries are valid, a fill replaces the entry at a round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping, after each such replacement.
- R12: When `fill_req` and `lk_req` are high in the same cycle, the fill is performed and the lookup is dropped: `rsp_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| fill_req | input | 1 | Write a fetched descriptor |
| fill_vpn | input | 20 | Virtual page of the descriptor |
| fill_ppn | input | 20 | Physical page of the descriptor |
| fill_global | input | 1 | Descriptor is shared by all contexts |
| cr_wr | input | 1 | Table-base register write |
| cr_data | input | 64 | Written value: [11:0] context, [62:12] base, [63] drop-context command |
| tag_en | input | 1 | Context tagging enabled for this write |
| inv_req | input | 1 | Invalidate non-global entries of one context |
| inv_ctx | input | 12 | Context to invalidate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup found a usable entry |
| rsp_ppn | output | 20 | Translated physical page, 0 on a miss |
| cur_ctx | output | 12 | Active context |
| tbl_base | output | 51 | Stored table base bits 62:12 |

## Verification
The bench targets the points where tagging goes wrong. It switches contexts and looks up the same page, so a design that ignores the tag returns a stale page. It looks up a global entry under a foreign context, so a design that tags globals reports a miss. It issues a targeted drop with bit 63 set and an invalidate through the command port, so a design that clears the wrong set either loses globals or keeps stale entries. It fills a full cache and then opens holes in it, so a design that ignores invalid slots or advances the pointer wrongly evicts the wrong page. A same-cycle fill and lookup checks that the lookup is dropped rather than answered.

// File: rtl/tlb_pkg.sv
// Shared constants and types for the context-tagged translation cache.
// Assumes a 64-bit table-base register whose low bits carry the context.
package tlb_pkg;
    localparam int CTX_W     = 12;          // context tag width
    localparam int CR_W      = 64;          // table-base register width
    localparam int DROP_BIT  = CR_W - 1;    // drop-context command bit
    localparam int BASE_LO   = CTX_W;       // lowest base bit
    localparam int BASE_HI   = CR_W - 2;    // highest base bit
    localparam int BASE_W    = BASE_HI - BASE_LO + 1;

    // Effect of a table-base write on stored entries
    typedef enum logic [1:0] {
        CR_KEEP      = 2'd0,
        CR_DROP_ALL  = 2'd1,
        CR_DROP_CTX  = 2'd2
    } cr_act_e;
endpackage

// File: rtl/tlb_ctx_ctl.sv
// Table-base register and active context.
// Decodes each write into an action on the entries (combinational, same
// cycle as the write) and registers the new context and base.
// Assumes tag_en is meaningful only while cr_wr is high.
module tlb_ctx_ctl
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cr_wr,
    input  logic [CR_W-1:0]   cr_data,
    input  logic              tag_en,
    output cr_act_e           act,
    output logic [CTX_W-1:0]  new_ctx,
    output logic [CTX_W-1:0]  cur_ctx,
    output logic [BASE_W-1:0] tbl_base
);
    // Decide what a write does to stored entries
    always_comb begin
        new_ctx = cr_data[CTX_W-1:0];
        if (!cr_wr)
            act = CR_KEEP;
        else if (!tag_en)
            act = CR_DROP_ALL;
        else if (cr_data[DROP_BIT])
            act = CR_DROP_CTX;
        else
            act = CR_KEEP;
    end

    // Hold the active context and table base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ctx  <= '0;
            tbl_base <= '0;
        end else if (cr_wr) begin
            cur_ctx  <= cr_data[CTX_W-1:0];
            tbl_base <= cr_data[BASE_HI:BASE_LO];
        end
    end

    // R5
    ctx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_wr |=> (cur_ctx == $past(cr_data[CTX_W-1:0])));
endmodule

// File: rtl/tlb_victim_sel.sv
// Replacement choice for a fill.
// Picks the lowest invalid entry if there is one, otherwise the entry at a
// round-robin pointer, which advances only when a valid entry is replaced.
module tlb_victim_sel #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic               fill_req,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Find the lowest-numbered free entry
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i])
                free_idx = IDX_W'(i);
        end
        any_free = ~&valid;
        victim   = any_free ? free_idx : rr_ptr;
    end

    // Advance the pointer after replacing a valid entry
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (fill_req && !any_free)
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end

    // R10
    victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && any_free) |-> !valid[victim]);
endmodule

// File: rtl/tlb_entry_array.sv
// Entry storage and match logic.
// Each entry holds valid, global, context tag, virtual and physical page.
// A write to an entry takes priority over any invalidation of it in the
// same cycle. Two context-drop channels may act in one cycle.
// Assumes no two valid entries hold the same page for the same context.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [CTX_W-1:0]   cur_ctx,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic               wr_glb,
    input  logic [CTX_W-1:0]   wr_ctx,
    input  logic               drop_all,
    input  logic               drop_a_en,
    input  logic [CTX_W-1:0]   drop_a_ctx,
    input  logic               drop_b_en,
    input  logic [CTX_W-1:0]   drop_b_ctx,
    output logic [ENTRIES-1:0] valid,
    output logic               hit,
    output logic [PPN_W-1:0]   hit_ppn
);
    logic [ENTRIES-1:0] glb;
    logic [CTX_W-1:0]   tag   [ENTRIES];
    logic [VPN_W-1:0]   vpn   [ENTRIES];
    logic [PPN_W-1:0]   ppn   [ENTRIES];
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic dropped;

        // Decide whether this entry is invalidated this cycle
        always_comb begin
            dropped = drop_all
                   || (drop_a_en && !glb[g] && tag[g] == drop_a_ctx)
                   || (drop_b_en && !glb[g] && tag[g] == drop_b_ctx);
        end

        // Store a fill or clear the valid bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[g] <= 1'b0;
                glb[g]   <= 1'b0;
                tag[g]   <= '0;
                vpn[g]   <= '0;
                ppn[g]   <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid[g] <= 1'b1;
                glb[g]   <= wr_glb;
                tag[g]   <= wr_ctx;
                vpn[g]   <= wr_vpn;
                ppn[g]   <= wr_ppn;
            end else if (dropped) begin
                valid[g] <= 1'b0;
            end
        end

        // Compare against the lookup page under the active context
        always_comb begin
            match[g] = valid[g] && vpn[g] == lk_vpn
                    && (glb[g] || tag[g] == cur_ctx);
        end
    end

    // Merge matching entries into one result
    always_comb begin
        hit     = |match;
        hit_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i])
                hit_ppn = hit_ppn | ppn[i];
        end
    end

    // R6
    drop_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_all && !wr_en) |=> (valid == '0));

    // R11
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid != '0));
endmodule

// File: rtl/tlb_ctx_cache.sv
// Context-tagged fully associative translation cache (top level).
// Lookups answer one cycle after the request; a fill in the same cycle
// wins and the lookup is dropped. Table-base writes and the invalidate
// port act on stored entries as decoded by the context controller.
module tlb_ctx_cache
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              fill_req,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_global,
    input  logic              cr_wr,
    input  logic [CR_W-1:0]   cr_data,
    input  logic              tag_en,
    input  logic              inv_req,
    input  logic [CTX_W-1:0]  inv_ctx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [CTX_W-1:0]  cur_ctx,
    output logic [BASE_W-1:0] tbl_base
);
    cr_act_e            act;
    logic [CTX_W-1:0]   new_ctx;
    logic [ENTRIES-1:0] valid;
    logic [IDX_W-1:0]   victim;
    logic               hit;
    logic [PPN_W-1:0]   hit_ppn;
    logic               lk_take;

    tlb_ctx_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cr_wr    (cr_wr),
        .cr_data  (cr_data),
        .tag_en   (tag_en),
        .act      (act),
        .new_ctx  (new_ctx),
        .cur_ctx  (cur_ctx),
        .tbl_base (tbl_base)
    );

    tlb_victim_sel #(.ENTRIES(ENTRIES)) u_vsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (valid),
        .fill_req (fill_req),
        .victim   (victim)
    );

    tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (lk_vpn),
        .cur_ctx    (cur_ctx),
        .wr_en      (fill_req),
        .wr_idx     (victim),
        .wr_vpn     (fill_vpn),
        .wr_ppn     (fill_ppn),
        .wr_glb     (fill_global),
        .wr_ctx     (cur_ctx),
        .drop_all   (act == CR_DROP_ALL),
        .drop_a_en  (act == CR_DROP_CTX),
        .drop_a_ctx (new_ctx),
        .drop_b_en  (inv_req),
        .drop_b_ctx (inv_ctx),
        .valid      (valid),
        .hit        (hit),
        .hit_ppn    (hit_ppn)
    );

    // A lookup is served only when no fill competes for the cycle
    always_comb lk_take = lk_req && !fill_req;

    // Register the lookup result for the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
        end else begin
            rsp_valid <= lk_take;
            rsp_hit   <= lk_take && hit;
            rsp_ppn   <= (lk_take && hit) ? hit_ppn : '0;
        end
    end

    // R2 R12
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_req && !fill_req));

    // R7
    keep_entries_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && tag_en && !cr_data[DROP_BIT] && !inv_req && !fill_req)
            |=> $stable(valid));
endmodule

// File: tb/tlb_ctx_cache_tb_top.sv
// Directed bench for the context-tagged translation cache.
module tlb_ctx_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        fill_req = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_global = 1'b0;
    logic        cr_wr = 1'b0;
    logic [63:0] cr_data = '0;
    logic        tag_en = 1'b0;
    logic        inv_req = 1'b0;
    logic [11:0] inv_ctx = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [19:0] rsp_ppn;
    logic [11:0] cur_ctx;
    logic [50:0] tbl_base;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tlb_ctx_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vpn(lk_vpn),
        .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_global(fill_global),
        .cr_wr(cr_wr), .cr_data(cr_data), .tag_en(tag_en),
        .inv_req(inv_req), .inv_ctx(inv_ctx),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .cur_ctx(cur_ctx), .tbl_base(tbl_base)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle lookup; result sampled at the next falling edge
    task automatic lookup(input logic [19:0] vpn, output logic v, output logic h, output logic [19:0] p);
        lk_vpn = vpn; lk_req = 1'b1;
        @(negedge clk);
        lk_req = 1'b0;
        v = rsp_valid; h = rsp_hit; p = rsp_ppn;
    endtask

    task automatic expect_hit(input string req, input logic [19:0] vpn, input logic [19:0] ppn);
        logic v, h; logic [19:0] p;
        lookup(vpn, v, h, p);
        check(req, {62'd0, v, h}, 64'd3);
        check(req, {44'd0, p}, {44'd0, ppn});
    endtask

    task automatic expect_miss(input string req, input logic [19:0] vpn);
        logic v, h; logic [19:0] p;
        lookup(vpn, v, h, p);
        check(req, {42'd0, v, h, p}, {42'd0, 1'b1, 1'b0, 20'd0});
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic g);
        fill_vpn = vpn; fill_ppn = ppn; fill_global = g; fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0; fill_global = 1'b0;
    endtask

    task automatic cr_write(input logic [63:0] val, input logic en);
        cr_data = val; tag_en = en; cr_wr = 1'b1;
        @(negedge clk);
        cr_wr = 1'b0; tag_en = 1'b0;
    endtask

    task automatic inv(input logic [11:0] ctx);
        inv_ctx = ctx; inv_req = 1'b1;
        @(negedge clk);
        inv_req = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 cur_ctx", {52'd0, cur_ctx}, 64'd0);
        expect_miss("R1 empty", 20'h5);
    endtask

    task automatic t_tags;
        cr_write(64'h1, 1'b1);
        fill(20'h10, 20'hA1, 1'b0);
        expect_hit("R2 R3 own ctx", 20'h10, 20'hA1);
        cr_write(64'h2, 1'b1);
        expect_miss("R3 other ctx", 20'h10);
        fill(20'h20, 20'hB2, 1'b1);
        cr_write(64'h3, 1'b1);
        expect_hit("R4 global", 20'h20, 20'hB2);
        cr_write(64'h1, 1'b1);
        expect_hit("R7 kept", 20'h10, 20'hA1);
    endtask

    task automatic t_drop_ctx;
        fill(20'h11, 20'hA2, 1'b0);
        cr_write(64'h2, 1'b1);
        fill(20'h30, 20'hC3, 1'b0);
        cr_write({1'b1, 63'h1}, 1'b1);
        check("R8 ctx", {52'd0, cur_ctx}, 64'd1);
        expect_miss("R8 dropped a", 20'h10);
        expect_miss("R8 dropped b", 20'h11);
        expect_hit("R8 global kept", 20'h20, 20'hB2);
        cr_write(64'h2, 1'b1);
        expect_hit("R8 other ctx kept", 20'h30, 20'hC3);
    endtask

    task automatic t_inv;
        cr_write(64'h1, 1'b1);
        fill(20'h12, 20'hA3, 1'b0);
        cr_write(64'h2, 1'b1);
        inv(12'h2);
        expect_miss("R9 invalidated", 20'h30);
        expect_hit("R9 global kept", 20'h20, 20'hB2);
        cr_write(64'h1, 1'b1);
        expect_hit("R9 other ctx kept", 20'h12, 20'hA3);
    endtask

    task automatic t_disable;
        logic [63:0] v;
        v = {1'b0, 51'h1234_5678_9ABC, 12'h005};
        cr_write(v, 1'b0);
        check("R5 ctx", {52'd0, cur_ctx}, 64'd5);
        check("R5 base", {13'd0, tbl_base}, {13'd0, v[62:12]});
        expect_miss("R6 global gone", 20'h20);
        cr_write(64'h1, 1'b1);
        expect_miss("R6 entry gone", 20'h12);
    endtask

    task automatic t_replace;
        cr_write(64'h0, 1'b0);
        cr_write(64'h7, 1'b1);
        for (int i = 0; i < 5; i++) fill(20'h40 + 20'(i), 20'h100 + 20'(i), 1'b0);
        cr_write(64'h8, 1'b1);
        for (int i = 5; i < 8; i++) fill(20'h40 + 20'(i), 20'h100 + 20'(i), 1'b0);
        cr_write(64'h7, 1'b1);
        fill(20'h48, 20'h108, 1'b0);
        expect_miss("R11 slot0 evicted", 20'h40);
        expect_hit("R11 new entry", 20'h48, 20'h108);
        expect_hit("R11 slot1 kept", 20'h41, 20'h101);
        inv(12'h8);
        fill(20'h49, 20'h109, 1'b0);
        expect_hit("R10 free slot used", 20'h41, 20'h101);
        expect_hit("R10 new entry", 20'h49, 20'h109);
        fill(20'h4A, 20'h10A, 1'b0);
        fill(20'h4B, 20'h10B, 1'b0);
        expect_hit("R10 slot1 still kept", 20'h41, 20'h101);
        fill(20'h4C, 20'h10C, 1'b0);
        expect_miss("R11 slot1 evicted", 20'h41);
        expect_hit("R11 slot2 kept", 20'h42, 20'h102);
        expect_hit("R11 newest", 20'h4C, 20'h10C);
    endtask

    task automatic t_collide;
        fill_vpn = 20'h50; fill_ppn = 20'h150; fill_global = 1'b0; fill_req = 1'b1;
        lk_vpn = 20'h43; lk_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0; lk_req = 1'b0;
        check("R12 lookup dropped", {63'd0, rsp_valid}, 64'd0);
        expect_hit("R12 fill done", 20'h50, 20'h150);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tags();
        t_drop_ctx();
        t_inv();
        t_disable();
        t_replace();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule